// File: doc/BRIEF.md
# Bit-Stream Digital Integrator

This block integrates a single-bit pulse-density stream and re-emits the integral as another single-bit stream. Each bit taken from the input stream is compared with a zero-reference square wave that the block generates itself. The zero reference alternates 0,1,0,1 on successive accepted bits. When the input carries a 1 while the reference is 0, the comparison yields +1. When the input carries a 0 while the reference is 1, it yields -1. Every other case yields 0. The result goes into a signed, saturating accumulator of `ACC_W` bits.

A first-order sign-feedback modulator turns the accumulator word back into a bit stream. Its feedback step is half the frame length N = 2^`ACC_W`, so the density of ones in the output tracks the accumulator value with unity gain. An input stream that encodes a constant B in a frame of N bits raises the accumulator by B/N per bit on average. The continuous-time equivalent gain is therefore the bit rate divided by N. Two of these blocks in a negative feedback loop form an oscillator.

Both the input and output streams use valid/ready handshakes. One integration step takes one input bit and produces one output bit. The zero reference and the modulator advance only on a step, so back-pressure slows the bit rate but leaves the result unchanged. An initialise level loads a preset into the accumulator and holds it there.

Top module: `bit_stream_integrator`

## Requirements
- R1: After reset, `acc_value` is 0, `out_valid` is 0, `in_ready` is 1, and the zero reference of the first step is 0.
- R2: A step happens on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` equals `!init && (!out_valid || out_ready)`. Without a step, `acc_value` holds.
- R3: On a step, the increment is +1 if `in_bit`=1 and the reference is 0, -1 if `in_bit`=0 and the reference is 1, and 0 otherwise. The reference inverts after every step.
- R4: The accumulator saturates at +2^(ACC_W-1)-1 and at -2^(ACC_W-1). It never wraps.
- R5: While `init` is 1, `acc_value` follows `init_value` one cycle later and no step is taken. `init` also clears the reference to 0, clears the modulator state to 0 and clears `out_valid`.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_bit` is stable.
- R7: On a step, `out_bit` becomes 1 exactly when the modulator state v is ≥ 0. v then moves by the pre-step accumulator value, minus 2^(ACC_W-1) when the bit is 1 and plus 2^(ACC_W-1) when it is 0. `out_valid` rises after every step.
- R8: With the accumulator held at A, 2N output bits (starting from a cleared modulator) contain 2·(N/2 + A) ones, within ±2.
- R9: An all-ones input stream raises the accumulator by N/2 per N steps (gain of bit rate over N). An all-zeros input stream lowers it by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Load-and-hold level for the accumulator |
| init_value | input | ACC_W | Signed preset for the accumulator |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can take an input bit |
| in_bit | input | 1 | Input stream bit |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Consumer takes the output bit |
| out_bit | output | 1 | Output stream bit |
| acc_value | output | ACC_W | Signed accumulator word |

## Verification
The bench goes after the reference phase: a design whose reference toggles per clock instead of per step would drift under back-pressure and miscount. It goes after both saturation rails, where a wrapping adder would jump to the opposite rail. It covers init during a stalled output, which must drop `out_valid` and restart the reference at 0. It checks output density for a positive and a negative held value. A modulator with the wrong feedback sign or step would produce a density far from N/2 + A. Random streams with random stalls are compared bit by bit against a model built from the rules above.

// File: rtl/bsi_pkg.sv
package bsi_pkg;
  // increment produced by one reference comparison
  typedef enum logic [1:0] {
    INC_NONE = 2'b00,
    INC_UP   = 2'b01,
    INC_DOWN = 2'b11
  } inc_e;
endpackage

// File: rtl/bsi_ref_decode.sv
module bsi_ref_decode
  import bsi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  input  logic bit_in,
  output inc_e inc
);
  logic zref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       zref_q <= 1'b0;
    else if (clear)   zref_q <= 1'b0;
    else if (advance) zref_q <= ~zref_q;
  end

  always_comb begin
    if (bit_in && !zref_q)      inc = INC_UP;
    else if (!bit_in && zref_q) inc = INC_DOWN;
    else                        inc = INC_NONE;
  end
endmodule

// File: rtl/bsi_sat_acc.sv
module bsi_sat_acc
  import bsi_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] load_val,
  input  logic                    en,
  input  inc_e                    inc,
  output logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] TOP = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BOT = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0]   wide;
  logic signed [ACC_W:0]   step;
  logic signed [ACC_W-1:0] next;

  always_comb begin
    step = {{(ACC_W-1){inc[1]}}, inc};
    wide = {acc[ACC_W-1], acc} + step;
    if (wide[ACC_W] != wide[ACC_W-1]) next = wide[ACC_W] ? BOT : TOP;
    else                              next = wide[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (load) acc <= load_val;
    else if (en)   acc <= next;
  end
endmodule

// File: rtl/bsi_sd_mod.sv
module bsi_sd_mod #(
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] x,
  output logic                    bit_now
);
  localparam int VW = ACC_W + 2;
  localparam logic signed [VW-1:0] HALF = VW'(1) <<< (ACC_W - 1);

  logic signed [VW-1:0] v_q;
  logic signed [VW-1:0] v_d;

  always_comb begin
    bit_now = ~v_q[VW-1];
    v_d = v_q + {{2{x[ACC_W-1]}}, x} - (bit_now ? HALF : -HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     v_q <= '0;
    else if (clear) v_q <= '0;
    else if (en)    v_q <= v_d;
  end
endmodule

// File: rtl/bit_stream_integrator.sv
module bit_stream_integrator
  import bsi_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [ACC_W-1:0] init_value,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic [ACC_W-1:0] acc_value
);
  logic                    fire;
  inc_e                    inc;
  logic signed [ACC_W-1:0] acc;
  logic                    mod_bit;

  assign in_ready  = !init && (!out_valid || out_ready);
  assign fire      = in_valid && in_ready;
  assign acc_value = acc;

  bsi_ref_decode u_dec (
    .clk(clk), .rst_n(rst_n), .clear(init), .advance(fire),
    .bit_in(in_bit), .inc(inc)
  );

  bsi_sat_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(init), .load_val(init_value),
    .en(fire), .inc(inc), .acc(acc)
  );

  bsi_sd_mod #(.ACC_W(ACC_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .clear(init), .en(fire),
    .x(acc), .bit_now(mod_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (init) begin
      out_valid <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_bit   <= mod_bit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bsi_checker.sv
module bsi_checker #(
  parameter int ACC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic [ACC_W-1:0] init_value,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_bit,
  input logic [ACC_W-1:0] acc_value
);
  localparam logic [ACC_W-1:0] TOP = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] BOT = {1'b1, {(ACC_W-1){1'b0}}};

  // R5
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> acc_value == $past(init_value));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !(in_valid && in_ready)) |=> $stable(acc_value));

  // R4
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && acc_value == TOP) |=> acc_value != BOT);

  // R4
  no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && acc_value == BOT) |=> acc_value != TOP);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !init) |=> out_valid && $stable(out_bit));

  // R7
  out_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind bit_stream_integrator bsi_checker #(.ACC_W(ACC_W)) u_bsi_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .init_value(init_value),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_bit(out_bit), .acc_value(acc_value)
);

// File: tb/tb_bit_stream_integrator.sv
`timescale 1ns/1ps
module tb_bit_stream_integrator;
  localparam int W = 8;
  localparam int N = 1 << W;
  localparam int M = N / 2;

  logic clk = 0, rst_n = 0, init = 0, in_valid = 0, in_bit = 0, out_ready = 1;
  logic [W-1:0] init_value = '0;
  logic in_ready, out_valid, out_bit;
  logic [W-1:0] acc_value;

  int total = 0, bad = 0;
  int m_acc = 0, m_v = 0, m_ob = 0;
  bit m_z = 0, m_ov = 0, done = 0;
  int ones = 0;

  always #2 clk = ~clk;

  bit_stream_integrator #(.ACC_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .init(init), .init_value(init_value),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .acc_value(acc_value)
  );

  function automatic int sat(input int a);
    if (a > M - 1) return M - 1;
    if (a < -M) return -M;
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, compare after the edge
  task automatic cyc(input bit iv, input bit ib, input bit ordy, input bit ini, input int ival);
    bit rdy, fire, ob;
    int inc;
    @(negedge clk);
    in_valid = iv; in_bit = ib; out_ready = ordy; init = ini;
    init_value = W'(ival);
    rdy = !ini && (!m_ov || ordy);
    fire = iv && rdy;
    #0.5;
    chk(in_ready == rdy, "R2 in_ready", in_ready, rdy);
    @(posedge clk);
    if (ini) begin
      m_acc = ival; m_z = 0; m_v = 0; m_ov = 0;
    end else if (fire) begin
      ob = (m_v >= 0);
      m_v = m_v + m_acc - (ob ? M : -M);
      inc = (ib && !m_z) ? 1 : ((!ib && m_z) ? -1 : 0);
      m_acc = sat(m_acc + inc);
      m_z = !m_z;
      m_ov = 1; m_ob = ob;
      if (ob) ones++;
    end else if (ordy) m_ov = 0;
    #1;
    chk($signed(acc_value) == m_acc, "R3/R4 acc_value", $signed(acc_value), m_acc);
    chk(out_valid == m_ov, "R7 out_valid", out_valid, m_ov);
    if (m_ov) chk(out_bit == m_ob, "R7 out_bit", out_bit, m_ob);
  endtask

  initial begin
    #(4ns * 190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a0, seed;
    seed = $urandom(32'h5eed);
    #9; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk($signed(acc_value) == 0, "R1 acc", $signed(acc_value), 0);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    // R3 zero-valued stream leaves accumulator at 0
    for (int i = 0; i < 32; i++) cyc(1, i[0], 1, 0, 0);
    chk($signed(acc_value) == 0, "R3 zero stream", $signed(acc_value), 0);
    // R9 all-ones slope: +8 per 16 steps
    cyc(0, 0, 1, 1, 0);
    for (int f = 1; f <= 4; f++) begin
      for (int i = 0; i < 16; i++) cyc(1, 1, 1, 0, 0);
      chk($signed(acc_value) == 8 * f, "R9 ones slope", $signed(acc_value), 8 * f);
    end
    // R9 all-zeros slope
    cyc(0, 0, 1, 1, 0);
    for (int f = 1; f <= 4; f++) begin
      for (int i = 0; i < 16; i++) cyc(1, 0, 1, 0, 0);
      chk($signed(acc_value) == -8 * f, "R9 zeros slope", $signed(acc_value), -8 * f);
    end
    // R4 positive rail
    cyc(0, 0, 1, 1, M - 2);
    for (int i = 0; i < 12; i++) cyc(1, 1, 1, 0, 0);
    chk($signed(acc_value) == M - 1, "R4 top rail", $signed(acc_value), M - 1);
    // R4 negative rail
    cyc(0, 0, 1, 1, -M + 1);
    for (int i = 0; i < 12; i++) cyc(1, 0, 1, 0, 0);
    chk($signed(acc_value) == -M, "R4 bottom rail", $signed(acc_value), -M);
    // R5 init holds value, blocks steps
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 1, 17);
    chk($signed(acc_value) == 17, "R5 init hold", $signed(acc_value), 17);
    // R6 back-pressure: output stalled
    cyc(1, 1, 1, 0, 0);
    a0 = $signed(acc_value);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0);
    chk(out_valid == 1, "R6 held valid", out_valid, 1);
    chk($signed(acc_value) == a0, "R2 stalled acc", $signed(acc_value), a0);
    // R5 init during stall drops out_valid
    cyc(1, 0, 0, 1, 0);
    chk(out_valid == 0, "R5 init clears valid", out_valid, 0);
    // R8 density, two held values
    for (int k = 0; k < 2; k++) begin
      a0 = (k == 0) ? 40 : -100;
      cyc(0, 0, 1, 1, a0);
      ones = 0;
      for (int i = 0; i < 2 * N; i++) cyc(1, i[0], 1, 0, 0);
      chk(ones >= 2 * (M + a0) - 2 && ones <= 2 * (M + a0) + 2, "R8 density",
          ones, 2 * (M + a0));
    end
    // constrained random with stalls
    cyc(0, 0, 1, 1, 0);
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) != 0,
          ($urandom % 200) == 0, int'($urandom % N) - M);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule